// File: doc/BRIEF.md
# Tile Address Increment

This block holds the 15-bit address a tile renderer uses to walk its background map, and advances it in response to step strobes. The address packs four fields: coarse column in bits 4:0, coarse row in bits 9:5, a two-bit map select in bits 11:10 (bit 10 picks the left or right map, bit 11 the upper or lower one), and fine row in bits 14:12. A column step moves one tile to the right. A row step moves one scanline down.

Column steps cross into the horizontally adjacent map after the 32nd tile. Row steps first advance the fine row. When the fine row rolls over, the coarse row advances, and it crosses into the vertically adjacent map after row 29, since the visible screen is 30 rows tall. A coarse row that was loaded with 30 or 31 counts on to 31 and then returns to 0 without changing maps. Steps are honoured only while rendering is enabled. A load strobe replaces the whole address and takes priority over both steps. The output is presented as a 16-bit view whose top bit is always zero.

Top module: `tile_addr_step`

## Requirements
- R1: While reset is asserted, and after it is released, the address reads 0 until something changes it.
- R2: Bit 15 of the 16-bit output is 0 in every cycle.
- R3: A column step with coarse column (bits 4:0) below 31 adds one to coarse column and leaves bits 14:5 unchanged.
- R4: A column step with coarse column equal to 31 sets coarse column to 0, inverts bit 10, and leaves all other bits unchanged.
- R5: A row step with fine row (bits 14:12) below 7 adds one to fine row and leaves bits 11:0 unchanged.
- R6: A row step with fine row 7 and coarse row (bits 9:5) equal to 29 sets fine row and coarse row to 0 and inverts bit 11.
- R7: A row step with fine row 7 and any coarse row other than 29 sets fine row to 0, leaves bit 11 unchanged, and sets coarse row to 0 if it was 31 and to coarse row plus one otherwise (so 30 becomes 31).
- R8: While rendering is disabled, column and row steps have no effect and the address holds its value.
- R9: A load strobe makes the address equal the load value on the next cycle, whatever the step strobes and the rendering enable are doing.
- R10: When column and row steps arrive in the same cycle, both are applied to their own fields in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| renderEn | input | 1 | Rendering enable; gates both step strobes |
| stepCol | input | 1 | Column step strobe |
| stepRow | input | 1 | Row step strobe |
| loadEn | input | 1 | Load strobe, highest priority |
| loadAddr | input | 15 | Address written by a load |
| addrOut | output | 16 | Registered address; bit 15 is always 0 |

## Verification
On every cycle the checker confirms that the top bit stays zero and that an idle or disabled cycle leaves the address stable. It also confirms that a load lands exactly, and that each step changes its own field by the right amount. The carry into the map-select bits is checked both at the column edge and at row 29 and row 31. Only the bench's sweeps show the complete picture. These sweeps preload every coarse column and every coarse row, including 30 and 31, and walk every fine row value. They compare all 15 bits against an arithmetic model, so unintended changes in untouched fields and the full combined-step result are caught there.

// File: rtl/tile_addr_pkg.sv
`timescale 1ns/1ps
package tile_addr_pkg;
  localparam int COARSE_W = 5;
  localparam int FINE_W   = 3;
  localparam int MAP_W    = 2;
  localparam int ADDR_W   = COARSE_W * 2 + MAP_W + FINE_W;
  localparam int VIEW_W   = 16;
  localparam int LAST_ROW = 29;

  typedef struct packed {
    logic doLoad;
    logic doCol;
    logic doRow;
  } stepCmd_t;
endpackage

// File: rtl/tile_addr_ctrl.sv
`timescale 1ns/1ps
module tile_addr_ctrl
  import tile_addr_pkg::*;
(
  input  logic     renderEn,
  input  logic     stepCol,
  input  logic     stepRow,
  input  logic     loadEn,
  output stepCmd_t cmd
);
  always_comb begin
    cmd.doLoad = loadEn;
    cmd.doCol  = renderEn & stepCol & ~loadEn;
    cmd.doRow  = renderEn & stepRow & ~loadEn;
  end
endmodule

// File: rtl/tile_addr_datapath.sv
`timescale 1ns/1ps
module tile_addr_datapath
  import tile_addr_pkg::*;
#(
  parameter int LastRow = LAST_ROW
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCmd_t          cmd,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic [ADDR_W-1:0] addrQ
);
  localparam int ColLo  = 0;
  localparam int RowLo  = COARSE_W;
  localparam int MapLo  = 2 * COARSE_W;
  localparam int FineLo = MapLo + MAP_W;
  localparam logic [COARSE_W-1:0] ROW_END    = COARSE_W'(LastRow);
  localparam logic [COARSE_W-1:0] COARSE_TOP = '1;
  localparam logic [FINE_W-1:0]   FINE_TOP   = '1;

  logic [COARSE_W-1:0] colCur, rowCur, colNxt, rowNxt;
  logic [FINE_W-1:0]   fineCur, fineNxt;
  logic [MAP_W-1:0]    mapCur, mapNxt;
  logic [ADDR_W-1:0]   addrNxt;

  always_comb begin
    colCur  = addrQ[ColLo  +: COARSE_W];
    rowCur  = addrQ[RowLo  +: COARSE_W];
    mapCur  = addrQ[MapLo  +: MAP_W];
    fineCur = addrQ[FineLo +: FINE_W];

    colNxt  = colCur;
    rowNxt  = rowCur;
    mapNxt  = mapCur;
    fineNxt = fineCur;

    if (cmd.doCol) begin
      if (colCur == COARSE_TOP) begin
        colNxt    = '0;
        mapNxt[0] = ~mapCur[0];
      end else begin
        colNxt = colCur + 1'b1;
      end
    end

    if (cmd.doRow) begin
      if (fineCur != FINE_TOP) begin
        fineNxt = fineCur + 1'b1;
      end else begin
        fineNxt = '0;
        if (rowCur == ROW_END) begin
          rowNxt    = '0;
          mapNxt[1] = ~mapCur[1];
        end else if (rowCur == COARSE_TOP) begin
          rowNxt = '0;
        end else begin
          rowNxt = rowCur + 1'b1;
        end
      end
    end

    addrNxt = {fineNxt, mapNxt, rowNxt, colNxt};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            addrQ <= '0;
    else if (cmd.doLoad)  addrQ <= loadAddr;
    else                  addrQ <= addrNxt;
  end
endmodule

// File: rtl/tile_addr_step.sv
`timescale 1ns/1ps
module tile_addr_step
  import tile_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              renderEn,
  input  logic              stepCol,
  input  logic              stepRow,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic [VIEW_W-1:0] addrOut
);
  stepCmd_t          cmd;
  logic [ADDR_W-1:0] addrQ;

  tile_addr_ctrl u_ctrl (
    .renderEn (renderEn),
    .stepCol  (stepCol),
    .stepRow  (stepRow),
    .loadEn   (loadEn),
    .cmd      (cmd)
  );

  tile_addr_datapath #(.LastRow(LAST_ROW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .loadAddr (loadAddr),
    .addrQ    (addrQ)
  );

  generate
    if (VIEW_W > ADDR_W) begin : g_pad
      assign addrOut = {{(VIEW_W - ADDR_W){1'b0}}, addrQ};
    end else begin : g_nopad
      assign addrOut = addrQ[VIEW_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/tile_addr_chk.sv
`timescale 1ns/1ps
module tile_addr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        renderEn,
  input logic        stepCol,
  input logic        stepRow,
  input logic        loadEn,
  input logic [14:0] loadAddr,
  input logic [15:0] addrOut
);
  logic colGo, rowGo;
  assign colGo = !loadEn && renderEn && stepCol;
  assign rowGo = !loadEn && renderEn && stepRow;

  // R2
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrOut[15] == 1'b0);

  // R9
  load_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> addrOut[14:0] == $past(loadAddr));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !(renderEn && (stepCol || stepRow))) |=> $stable(addrOut));

  // R3
  col_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colGo && addrOut[4:0] != 5'd31) |=>
      (addrOut[4:0] == $past(addrOut[4:0]) + 5'd1) && (addrOut[10] == $past(addrOut[10])));

  // R4
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colGo && addrOut[4:0] == 5'd31) |=>
      (addrOut[4:0] == 5'd0) && (addrOut[10] != $past(addrOut[10])));

  // R5
  fine_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowGo && addrOut[14:12] != 3'd7) |=>
      (addrOut[14:12] == $past(addrOut[14:12]) + 3'd1) &&
      (addrOut[11] == $past(addrOut[11])) && (addrOut[9:5] == $past(addrOut[9:5])));

  // R6
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowGo && addrOut[14:12] == 3'd7 && addrOut[9:5] == 5'd29) |=>
      (addrOut[14:12] == 3'd0) && (addrOut[9:5] == 5'd0) && (addrOut[11] != $past(addrOut[11])));

  // R7
  row_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowGo && addrOut[14:12] == 3'd7 && addrOut[9:5] == 5'd31) |=>
      (addrOut[9:5] == 5'd0) && (addrOut[11] == $past(addrOut[11])));
endmodule

bind tile_addr_step tile_addr_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .renderEn (renderEn),
  .stepCol  (stepCol),
  .stepRow  (stepRow),
  .loadEn   (loadEn),
  .loadAddr (loadAddr),
  .addrOut  (addrOut)
);

// File: tb/tb_tile_addr_step.sv
`timescale 1ns/1ps
module tb_tile_addr_step;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        renderEn = 1'b0, stepCol = 1'b0, stepRow = 1'b0, loadEn = 1'b0;
  logic [14:0] loadAddr = '0;
  logic [15:0] addrOut;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tile_addr_step dut (
    .clk(clk), .rstN(rstN), .renderEn(renderEn), .stepCol(stepCol),
    .stepRow(stepRow), .loadEn(loadEn), .loadAddr(loadAddr), .addrOut(addrOut)
  );

  function automatic logic [14:0] refNext(input logic [14:0] a, input logic h, input logic v);
    int cx, cy, nt, fy;
    cx = int'(a[4:0]); cy = int'(a[9:5]); nt = int'(a[11:10]); fy = int'(a[14:12]);
    if (h) begin
      if (cx == 31) begin cx = 0; nt = nt ^ 1; end
      else cx = cx + 1;
    end
    if (v) begin
      if (fy < 7) fy = fy + 1;
      else begin
        fy = 0;
        if (cy == 29) begin cy = 0; nt = nt ^ 2; end
        else if (cy == 31) cy = 0;
        else cy = cy + 1;
      end
    end
    return 15'(fy * 4096 + nt * 1024 + cy * 32 + cx);
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    total++;
    if (addrOut !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, addrOut, exp);
    end
  endtask

  task automatic doLoad(input logic [14:0] a);
    loadEn = 1'b1; loadAddr = a;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic doStep(input logic en, input logic h, input logic v);
    renderEn = en; stepCol = h; stepRow = v;
    @(negedge clk);
    renderEn = 1'b0; stepCol = 1'b0; stepRow = 1'b0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [14:0] base, exp;
    @(negedge clk);
    check("R1 during reset", 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 16'h0000);

    // R3 / R4: every coarse column, both values of bit 10, other fields busy
    for (int c = 0; c < 32; c++) begin
      for (int m = 0; m < 2; m++) begin
        base = 15'({3'd5, 1'b1, m[0], 5'd17, c[4:0]});
        doLoad(base);
        check("R9 load", {1'b0, base});
        doStep(1'b1, 1'b1, 1'b0);
        exp = refNext(base, 1'b1, 1'b0);
        check(c == 31 ? "R4 col wrap" : "R3 col inc", {1'b0, exp});
        check("R2 top bit", {1'b0, exp});
      end
    end

    // R5: fine row walk
    for (int f = 0; f < 7; f++) begin
      base = 15'({f[2:0], 2'b10, 5'd12, 5'd9});
      doLoad(base);
      doStep(1'b1, 1'b0, 1'b1);
      check("R5 fine inc", {1'b0, refNext(base, 1'b0, 1'b1)});
    end

    // R6 / R7: every coarse row with fine row 7, both values of bit 11
    for (int r = 0; r < 32; r++) begin
      for (int m = 0; m < 2; m++) begin
        base = 15'({3'd7, m[0], 1'b1, r[4:0], 5'd3});
        doLoad(base);
        doStep(1'b1, 1'b0, 1'b1);
        exp = refNext(base, 1'b0, 1'b1);
        check(r == 29 ? "R6 row wrap" : "R7 row step", {1'b0, exp});
      end
    end

    // R7: preload 30 then keep stepping through 31 and back to 0
    base = 15'({3'd7, 2'b01, 5'd30, 5'd0});
    doLoad(base);
    for (int k = 0; k < 16; k++) begin
      doStep(1'b1, 1'b0, 1'b1);
      base = refNext(base, 1'b0, 1'b1);
      check("R7 row 30 run", {1'b0, base});
    end

    // R10: both steps together at all the corners
    for (int c = 29; c < 32; c++) begin
      for (int r = 28; r < 32; r++) begin
        base = 15'({3'd7, 2'b00, r[4:0], c[4:0]});
        doLoad(base);
        doStep(1'b1, 1'b1, 1'b1);
        check("R10 both steps", {1'b0, refNext(base, 1'b1, 1'b1)});
      end
    end

    // R8: steps ignored while rendering is off
    base = 15'({3'd7, 2'b11, 5'd29, 5'd31});
    doLoad(base);
    doStep(1'b0, 1'b1, 1'b1);
    check("R8 disabled", {1'b0, base});
    doStep(1'b0, 1'b1, 1'b0);
    check("R8 disabled col", {1'b0, base});

    // R9: load beats simultaneous steps, with and without rendering
    renderEn = 1'b1; stepCol = 1'b1; stepRow = 1'b1;
    doLoad(15'h5A5A);
    check("R9 load wins", 16'h5A5A);
    renderEn = 1'b0; stepCol = 1'b0; stepRow = 1'b0;
    doLoad(15'h7FFF);
    check("R9 load all ones", 16'h7FFF);
    check("R2 top bit", 16'h7FFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule